// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The RAM has 19 address bits and one shared 8-bit data bus. The host offers one byte-wide read or write at a time through a valid/ready handshake. The controller turns each request into the active-low chip-enable, write-enable and output-enable strobes that the RAM needs. For a read, it returns the byte together with a one-cycle done pulse. A write also ends with a done pulse.

Every strobe phase lasts a whole number of clock cycles. Each count is derived at elaboration from a nanosecond limit of the chosen speed grade and the clock period: the limit is divided by the period, rounded up, and never less than one cycle. A per-request mode input picks how a write ends. The write can end on the rising edge of write-enable while chip-enable stays low, or on the rising edge of chip-enable while write-enable stays low.

The controller keeps the bus free between operations. After a read it spaces the next access by the output turn-off time. It drives the data bus only inside a write. A retention input parks the RAM with chip-enable high. When retention is released, the controller waits one read-cycle time before it accepts the next access.

Back-pressure works as follows. The host holds `req_valid` and its fields stable until a clock edge where `req_ready` is high. That edge accepts the request. `req_ready` is low from the cycle after acceptance until the controller is idle again, and also whenever `sleep_req` is high. The result side has no back-pressure: the host must take `rsp_rdata` in the cycle where `rsp_done` is high.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip-enable, write-enable and output-enable are high, the data bus driver is off, `rsp_done` is low and `req_ready` is high.
- R2: A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the next cycle. Address, write data and the `end_on_ce` mode are captured at acceptance, so later changes on those inputs have no effect on the operation in progress. While `req_ready` is high, all three strobes are high and the bus driver is off.
- R3: A read lowers chip-enable and output-enable on the acceptance edge and holds them low, with write-enable high, for ACC cycles. The byte on `sram_dq_in` is captured on the edge that ends those cycles. `rsp_done` is high for one cycle after that edge, so it is seen ACC+1 edges after acceptance when the acceptance edge is counted.
- R4: A write with `end_on_ce`=0 lowers chip-enable and write-enable on the acceptance edge. Write-enable rises after PULSE cycles. Chip-enable rises HOLD cycles later.
- R5: A write with `end_on_ce`=1 lowers both strobes on the acceptance edge. Chip-enable rises after PULSE cycles. Write-enable rises HOLD cycles later.
- R6: The data bus driver turns on only together with a write's strobes and stays on for PULSE+HOLD cycles. Address and data are stable while it is on. It is never on while output-enable is low, and it is off for at least one cycle before output-enable falls.
- R7: The phase counts use cyc(t) = max(1, ceil(t / CLK_NS)). The counts are: ACC = max(cyc(T_RC), cyc(T_AA), cyc(T_OE)); HOLD = cyc(T_DH); PULSE = max(cyc(T_WP), cyc(T_CW), cyc(T_DW), cyc(T_WC) - HOLD, 1); TURN = cyc(T_OHZ); REC = cyc(T_REC).
- R8: After a read's done pulse, `req_ready` stays low for TURN more cycles.
- R9: When `sleep_req` is high in an idle cycle, `sleep_ack` goes high one edge later and chip-enable stays high. Requests are not accepted while `sleep_ack` or `sleep_req` is high. If an operation is in progress when `sleep_req` rises, that operation completes first and gives its done pulse.
- R10: After `sleep_req` falls, `sleep_ack` drops on the next edge, and `req_ready` returns REC+1 edges after the fall.
- R11: A write completes with `rsp_done` PULSE+HOLD+1 edges after acceptance, counting the acceptance edge. A read returns the byte most recently written at that address, across the full 19-bit address range, whichever mode the write used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| end_on_ce | input | 1 | Write end mode: 0 = write-enable rises first, 1 = chip-enable rises first |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte, valid with rsp_done after a read |
| sleep_req | input | 1 | Request the retention state |
| sleep_ack | output | 1 | RAM parked with chip-enable high |
| sram_addr | output | 19 | RAM address |
| sram_ce_n | output | 1 | RAM chip-enable, active low |
| sram_we_n | output | 1 | RAM write-enable, active low |
| sram_oe_n | output | 1 | RAM output-enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | 8 | Byte read from the data bus |

## Verification
The bench runs a slow speed grade at a 20 ns clock, which gives ACC=3, PULSE=3, HOLD=1, TURN=2 and REC=3. It computes these counts with its own copy of the R7 formula.

Each result has its own latency, counted in edges from acceptance including the acceptance edge: read done is due at ACC+1 and write done at PULSE+HOLD+1. After a read, ready is due TURN edges after done. After release of retention, ready is due REC+1 edges later.

The bench drives inputs and samples latencies at falling edges. A strobe monitor samples 2 ns after each rising edge and measures how many cycles each strobe stays low. Each measured width is compared with the count the bench computed.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_PULSE = 3'd2,
    ST_WR_HOLD  = 3'd3,
    ST_TURN     = 3'd4,
    ST_SLEEP    = 3'd5,
    ST_WAKE     = 3'd6
  } ctl_state_e;

  // Whole cycles covering a nanosecond limit, never fewer than one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned C_ACC   = 1,
  parameter int unsigned C_PULSE = 1,
  parameter int unsigned C_HOLD  = 1,
  parameter int unsigned C_TURN  = 1,
  parameter int unsigned C_REC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       end_on_ce,
  input  logic       sleep_req,
  output logic       req_ready,
  output logic       accept,
  output logic       cap_en,
  output logic       wr_fin,
  output ctl_state_e nxt_state,
  output logic       nxt_mode
);

  localparam logic [CNT_W-1:0] LV_ACC   = CNT_W'(C_ACC - 1);
  localparam logic [CNT_W-1:0] LV_PULSE = CNT_W'(C_PULSE - 1);
  localparam logic [CNT_W-1:0] LV_HOLD  = CNT_W'(C_HOLD - 1);
  localparam logic [CNT_W-1:0] LV_TURN  = CNT_W'(C_TURN - 1);
  localparam logic [CNT_W-1:0] LV_REC   = CNT_W'(C_REC - 1);

  ctl_state_e       state_q;
  logic             mode_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_ctl_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign req_ready = (state_q == ST_IDLE) && !sleep_req;
  assign accept    = req_ready && req_valid;
  assign cap_en    = (state_q == ST_RD) && tmr_zero;
  assign wr_fin    = (state_q == ST_WR_HOLD) && tmr_zero;

  always_comb begin
    nxt_state = state_q;
    nxt_mode  = mode_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          nxt_state = ST_SLEEP;
        end else if (req_valid) begin
          nxt_mode = end_on_ce;
          tmr_load = 1'b1;
          if (req_write) begin
            nxt_state = ST_WR_PULSE;
            tmr_val   = LV_PULSE;
          end else begin
            nxt_state = ST_RD;
            tmr_val   = LV_ACC;
          end
        end
      end
      ST_RD: if (tmr_zero) begin
        nxt_state = ST_TURN;
        tmr_load  = 1'b1;
        tmr_val   = LV_TURN;
      end
      ST_WR_PULSE: if (tmr_zero) begin
        nxt_state = ST_WR_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = LV_HOLD;
      end
      ST_WR_HOLD: if (tmr_zero) nxt_state = ST_IDLE;
      ST_TURN:    if (tmr_zero) nxt_state = ST_IDLE;
      ST_SLEEP: if (!sleep_req) begin
        nxt_state = ST_WAKE;
        tmr_load  = 1'b1;
        tmr_val   = LV_REC;
      end
      ST_WAKE:    if (tmr_zero) nxt_state = ST_IDLE;
      default:    nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= nxt_state;
      mode_q  <= nxt_mode;
    end
  end

endmodule

// File: rtl/sram_ctl_pads.sv
module sram_ctl_pads
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  ctl_state_e        nxt_state,
  input  logic              nxt_mode,
  input  logic              cap_en,
  input  logic              wr_fin,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sleep_ack
);

  logic ce_low_d, we_low_d, oe_low_d, drive_d, park_d;

  // Strobe levels follow the next state so every pin comes from a flop.
  always_comb begin
    ce_low_d = (nxt_state == ST_RD) || (nxt_state == ST_WR_PULSE) ||
               ((nxt_state == ST_WR_HOLD) && !nxt_mode);
    we_low_d = (nxt_state == ST_WR_PULSE) ||
               ((nxt_state == ST_WR_HOLD) && nxt_mode);
    oe_low_d = (nxt_state == ST_RD);
    drive_d  = (nxt_state == ST_WR_PULSE) || (nxt_state == ST_WR_HOLD);
    park_d   = (nxt_state == ST_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      sleep_ack  <= 1'b0;
      rsp_done   <= 1'b0;
    end else begin
      sram_ce_n  <= !ce_low_d;
      sram_we_n  <= !we_low_d;
      sram_oe_n  <= !oe_low_d;
      sram_dq_oe <= drive_d;
      sleep_ack  <= park_d;
      rsp_done   <= cap_en || wr_fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= sram_dq_in;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_RC_NS   = 20,
  parameter int unsigned T_AA_NS   = 20,
  parameter int unsigned T_OE_NS   = 13,
  parameter int unsigned T_WC_NS   = 20,
  parameter int unsigned T_WP_NS   = 15,
  parameter int unsigned T_CW_NS   = 15,
  parameter int unsigned T_DW_NS   = 12,
  parameter int unsigned T_DH_NS   = 3,
  parameter int unsigned T_OHZ_NS  = 8,
  parameter int unsigned T_REC_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              end_on_ce,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sleep_req,
  output logic              sleep_ack,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned C_ACC  = umax(umax(ns_to_cyc(T_RC_NS, CLK_NS),
                                             ns_to_cyc(T_AA_NS, CLK_NS)),
                                        ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned C_HOLD = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int unsigned C_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned C_WC_REST = (C_WC > C_HOLD) ? (C_WC - C_HOLD) : 1;
  localparam int unsigned C_PULSE = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                              ns_to_cyc(T_CW_NS, CLK_NS)),
                                         umax(ns_to_cyc(T_DW_NS, CLK_NS),
                                              C_WC_REST));
  localparam int unsigned C_TURN = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned C_REC  = ns_to_cyc(T_REC_NS, CLK_NS);
  localparam int unsigned C_MAX  = umax(umax(C_ACC, C_PULSE),
                                        umax(umax(C_HOLD, C_TURN), C_REC));
  localparam int unsigned CNT_W  = $clog2(C_MAX + 1);

  logic       accept, cap_en, wr_fin, nxt_mode;
  ctl_state_e nxt_state;

  sram_ctl_fsm #(
    .CNT_W   (CNT_W),
    .C_ACC   (C_ACC),
    .C_PULSE (C_PULSE),
    .C_HOLD  (C_HOLD),
    .C_TURN  (C_TURN),
    .C_REC   (C_REC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .end_on_ce (end_on_ce),
    .sleep_req (sleep_req),
    .req_ready (req_ready),
    .accept    (accept),
    .cap_en    (cap_en),
    .wr_fin    (wr_fin),
    .nxt_state (nxt_state),
    .nxt_mode  (nxt_mode)
  );

  sram_ctl_pads #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pads (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .nxt_state   (nxt_state),
    .nxt_mode    (nxt_mode),
    .cap_en      (cap_en),
    .wr_fin      (wr_fin),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .sleep_ack   (sleep_ack)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MIN_PULSE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              sleep_ack,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 we_lo_cnt <= '0;
    else if (sram_we_n)         we_lo_cnt <= '0;
    else if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 8'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R2

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R6

  AST_GAP_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R6

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && !sram_ce_n)); // R6

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R6

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n)); // R3

  AST_PARK_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (sram_ce_n && !req_ready)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R11

  AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (32'(we_lo_cnt) >= MIN_PULSE)); // R7

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MIN_PULSE (C_PULSE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .sleep_ack   (sleep_ack),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;

  localparam int PER = 20;
  localparam int AW  = 19;

  function automatic int cyc(input int t);
    int c;
    c = (t + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Slow grade timing, nanoseconds
  localparam int E_ACC   = mx(mx(cyc(55), cyc(55)), cyc(40));
  localparam int E_HOLD  = cyc(3);
  localparam int E_PULSE = mx(mx(cyc(50), cyc(50)), mx(cyc(30), mx(cyc(55) - E_HOLD, 1)));
  localparam int E_TURN  = cyc(30);
  localparam int E_REC   = cyc(55);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PER/2) clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, end_on_ce = 1'b0, sleep_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rsp_done, sleep_ack;
  logic [7:0]    rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]    sram_dq_out;
  logic [7:0]    sram_dq_in = 8'hEE;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  sram_ctl #(
    .CLK_NS(PER), .T_RC_NS(55), .T_AA_NS(55), .T_OE_NS(40), .T_WC_NS(55),
    .T_WP_NS(50), .T_CW_NS(50), .T_DW_NS(30), .T_DH_NS(3), .T_OHZ_NS(30),
    .T_REC_NS(55)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .end_on_ce(end_on_ce), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sleep_req(sleep_req), .sleep_ack(sleep_ack), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // RAM model
  logic [7:0] mem [int];
  always @(posedge sram_we_n or posedge sram_ce_n) begin
    if ((sram_ce_n === 1'b0 && sram_we_n === 1'b1) ||
        (sram_ce_n === 1'b1 && sram_we_n === 1'b0)) begin
      chk(sram_dq_oe === 1'b1, "R6 bus driven at end of write", int'(sram_dq_oe), 1);
      mem[int'(sram_addr)] = sram_dq_out;
    end
  end
  always @(negedge clk) begin
    if (sram_ce_n === 1'b0 && sram_oe_n === 1'b0 && sram_we_n === 1'b1)
      sram_dq_in <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    else
      sram_dq_in <= 8'hEE;
  end

  // Strobe width monitor, 2 ns after each rising edge
  int we_c = 0, ce_c = 0, oe_c = 0, dq_c = 0;
  int last_we = 0, last_ce = 0, last_oe = 0, last_dq = 0;
  always @(posedge clk) begin
    #2;
    if (sram_we_n === 1'b0) we_c++; else if (we_c != 0) begin last_we = we_c; we_c = 0; end
    if (sram_ce_n === 1'b0) ce_c++; else if (ce_c != 0) begin last_ce = ce_c; ce_c = 0; end
    if (sram_oe_n === 1'b0) oe_c++; else if (oe_c != 0) begin last_oe = oe_c; oe_c = 0; end
    if (sram_dq_oe === 1'b1) dq_c++; else if (dq_c != 0) begin last_dq = dq_c; dq_c = 0; end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input logic [AW-1:0] a, input int k);
    return 8'(a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]}) + 8'(k * 29 + 3);
  endfunction

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic mode, output int lat, output logic [7:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; end_on_ce = mode;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; end_on_ce = ~mode; req_write = ~wr;
    lat = 1;
    while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
  endtask

  logic [AW-1:0] addrs [0:20];
  logic [7:0]    expv  [0:20];

  initial begin
    int lat;
    logic [7:0] rd;
    int n;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes high in reset", int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
    chk(!sram_dq_oe && !rsp_done, "R1 bus off and done low in reset", int'({sram_dq_oe, rsp_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 idle after reset", int'(sram_ce_n), 1);

    addrs[0] = '0;
    addrs[1] = '1;
    for (int b = 0; b < AW; b++) addrs[b + 2] = AW'(1) << b;

    // R4 R5 R11: write sweep, alternating end mode
    for (int i = 0; i < 21; i++) begin
      expv[i] = pat(addrs[i], i);
      do_op(1'b1, addrs[i], expv[i], i[0], lat, rd);
      chk(lat == E_PULSE + E_HOLD + 1, "R11 R7 write done latency", lat, E_PULSE + E_HOLD + 1);
      if (!i[0]) begin
        chk(last_we == E_PULSE, "R4 we low width", last_we, E_PULSE);
        chk(last_ce == E_PULSE + E_HOLD, "R4 ce low width", last_ce, E_PULSE + E_HOLD);
      end else begin
        chk(last_ce == E_PULSE, "R5 ce low width", last_ce, E_PULSE);
        chk(last_we == E_PULSE + E_HOLD, "R5 we low width", last_we, E_PULSE + E_HOLD);
      end
      chk(last_dq == E_PULSE + E_HOLD, "R6 bus drive width", last_dq, E_PULSE + E_HOLD);
    end

    // R3 R8 R11: read back sweep
    for (int i = 0; i < 21; i++) begin
      do_op(1'b0, addrs[i], 8'h00, 1'b0, lat, rd);
      chk(lat == E_ACC + 1, "R3 R7 read done latency", lat, E_ACC + 1);
      chk(rd == expv[i], "R11 read data", int'(rd), int'(expv[i]));
      chk(last_oe == E_ACC && last_ce == E_ACC, "R3 read strobe width", last_oe, E_ACC);
      n = 0;
      while (!req_ready && n < 50) begin @(negedge clk); n++; end
      chk(n == E_TURN, "R8 turnaround after read", n, E_TURN);
    end

    // R9: retention entry from idle, requests held off
    @(negedge clk);
    sleep_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = addrs[3]; req_wdata = 8'h5A;
    @(negedge clk);
    chk(sleep_ack === 1'b1, "R9 ack one edge after sleep_req", int'(sleep_ack), 1);
    repeat (4) begin
      @(negedge clk);
      chk(sram_ce_n && sram_we_n && !req_ready && !rsp_done, "R9 parked ignores request",
          int'({sram_ce_n, sram_we_n, req_ready, rsp_done}), 12);
    end
    req_valid = 1'b0;
    // R10: wake recovery
    sleep_req = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk(sleep_ack === 1'b0, "R10 ack drops", int'(sleep_ack), 0);
    end while (!req_ready && n < 50);
    chk(n == E_REC + 1, "R10 wake delay", n, E_REC + 1);
    do_op(1'b0, addrs[3], 8'h00, 1'b0, lat, rd);
    chk(rd == expv[3], "R9 parked request had no effect", int'(rd), int'(expv[3]));

    // R9: sleep request during a write lets it complete
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addrs[7]; req_wdata = 8'hC3; end_on_ce = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; sleep_req = 1'b1;
    n = 1;
    while (!rsp_done && n < 50) begin @(negedge clk); n++; end
    chk(n == E_PULSE + E_HOLD + 1, "R9 write finishes under sleep_req", n, E_PULSE + E_HOLD + 1);
    chk(sleep_ack === 1'b0, "R9 no ack during done", int'(sleep_ack), 0);
    @(negedge clk);
    chk(sleep_ack === 1'b1, "R9 ack after write", int'(sleep_ack), 1);
    sleep_req = 1'b0;
    do_op(1'b0, addrs[7], 8'h00, 1'b0, lat, rd);
    chk(rd == 8'hC3, "R11 data after sleep", int'(rd), 8'hC3);

    // R2: inputs changed after accept do not alter the operation
    do_op(1'b1, 19'h2A5A5, 8'h96, 1'b0, lat, rd);
    do_op(1'b0, 19'h2A5A5, 8'h00, 1'b0, lat, rd);
    chk(rd == 8'h96, "R2 captured fields used", int'(rd), 8'h96);
    do_op(1'b0, ~19'h2A5A5, 8'h00, 1'b0, lat, rd);
    chk(rd == (mem.exists(int'(~19'h2A5A5)) ? mem[int'(~19'h2A5A5)] : 8'h00),
        "R2 changed address not written", int'(rd), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule